// File: doc/BRIEF.md
# Mixed-Speed Serial Bus Bridge Controller

This controller runs the three switches of a bridge between a high-speed two-wire segment and a slower fast/standard-speed segment. It samples all four lines on the system clock and watches the high-speed pair for START and STOP conditions. It also captures the first byte after each START. While the bus is idle, or carrying an ordinary transfer, the bridge stays closed: the data lines are joined, the clock lines are joined, and the data pull-down is released.

When the first byte after START is a master code, the bridge splits the bus in a fixed order. It first separates the data lines, then pulls the slow data line low. It separates the clocks only once both clock lines are high. The slow segment then rests with its clock high and its data low, ready to see a STOP. A STOP on the high-speed data line rejoins the segments in reverse order, and the data lines are reconnected only after the slow data line has risen. If the slow clock is held low for a configurable number of cycles, in any state, the bridge is forced closed at once.

Top module: `mbb_bridge_ctrl`

## Requirements
- R1: After reset, and after any reset applied mid-transfer, `data_join_o`=1, `clk_join_o`=1, `sda_pull_o`=0 and `state_o`=0.
- R2: A first byte after START whose upper five bits are 00001 (bits sent MSB first) opens the data switch (`data_join_o`=0) and moves `state_o` to 1.
- R3: Any other first byte, including the reserved pattern 00000xxx, leaves all three switch outputs and `state_o` at their closed values.
- R4: `sda_pull_o` rises exactly one cycle after `data_join_o` falls, and is never 1 while `data_join_o` is 1.
- R5: After the acknowledge clock of the master code has gone low, `clk_join_o` falls only in a cycle where both synchronised clock lines are high. `state_o` then becomes 2.
- R6: In state 2, `data_join_o`=0, `clk_join_o`=0 and `sda_pull_o`=1 are held through high-speed clock and data activity.
- R7: A STOP in state 2 (high-speed data rises while the high-speed clock is high) sets `clk_join_o`=1 and `state_o`=3, and clears `sda_pull_o` on the following cycle.
- R8: In state 3, `data_join_o` returns to 1 only after the slow data line is sampled high. `state_o` then returns to 0.
- R9: If the slow clock is sampled low for HANG_CYCLES consecutive cycles, the next cycle forces the closed outputs and `state_o`=0. Any high sample restarts the count.
- R10: `state_o` encodes 0 closed, 1 splitting, 2 split, 3 rejoining.
- R11: A START or STOP is recognised only after the new data level has held for two synchronised samples while the clock stayed high, so a one-sample data pulse causes no transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdah_i | input | 1 | High-speed segment data line (sampled) |
| sclh_i | input | 1 | High-speed segment clock line (sampled) |
| sda_i | input | 1 | Slow segment data line (sampled) |
| scl_i | input | 1 | Slow segment clock line (sampled) |
| data_join_o | output | 1 | 1 = data switch conducts between the segments |
| clk_join_o | output | 1 | 1 = clock switch conducts between the segments |
| sda_pull_o | output | 1 | 1 = slow data line pulled to ground |
| state_o | output | 2 | Bridge state: 0 closed, 1 splitting, 2 split, 3 rejoining |

## Verification
Each line passes through two synchronising flops, so a line change reaches the control logic two edges after it is driven. A START or STOP needs one more sample before it is recognised, and each switch step then takes one further edge. A bus phase can therefore affect the outputs up to five edges after it is driven. The bench holds every bus phase for at least six cycles, or for ten when it must show that nothing changes, and samples only at the end of the phase. The single-cycle spacing between the data switch opening and the pull-down engaging is measured exactly, by recording the falling-edge cycle of each output.

// File: rtl/mbb_pkg.sv
package mbb_pkg;

    localparam int BYTE_W      = 8;
    localparam int SYNC_STAGES = 2;
    localparam int LINE_CNT    = 4;

    typedef enum logic [1:0] {
        BR_CLOSED    = 2'd0,
        BR_SPLITTING = 2'd1,
        BR_SPLIT     = 2'd2,
        BR_REJOIN    = 2'd3
    } br_state_e;

    typedef struct packed {
        logic sdah;
        logic sclh;
        logic sda;
        logic scl;
    } bus_lines_t;

    typedef struct packed {
        logic data_join;
        logic clk_join;
        logic sda_pull;
    } sw_ctl_t;

    localparam sw_ctl_t SW_CLOSED = '{data_join: 1'b1, clk_join: 1'b1, sda_pull: 1'b0};

    function automatic logic is_master_code(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:BYTE_W-5] == 5'b00001;
    endfunction

endpackage

// File: rtl/mbb_line_sync.sv
module mbb_line_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '1;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbb_cond_det.sv
module mbb_cond_det (
    input  logic clk,
    input  logic rst,
    input  logic dat_q,
    input  logic clk_q,
    output logic start_p,
    output logic stop_p,
    output logic clk_rise
);
    logic d1, d2, c1, c2;

    always_ff @(posedge clk) begin
        if (rst) begin
            d1 <= 1'b1; d2 <= 1'b1; c1 <= 1'b1; c2 <= 1'b1;
        end else begin
            d1 <= dat_q; d2 <= d1; c1 <= clk_q; c2 <= c1;
        end
    end

    logic clk_steady_hi;
    assign clk_steady_hi = clk_q & c1 & c2;
    // new data level must be present in two consecutive samples
    assign start_p  = clk_steady_hi &  d2 & ~d1 & ~dat_q;
    assign stop_p   = clk_steady_hi & ~d2 &  d1 &  dat_q;
    assign clk_rise = clk_q & ~c1;
endmodule

// File: rtl/mbb_byte_rx.sv
module mbb_byte_rx
    import mbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              clk_rise,
    input  logic              dat_q,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CW = $clog2(BYTE_W + 1);

    logic          armed;
    logic [CW-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            bit_cnt  <= '0;
            byte_q   <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (start_p) begin
                armed   <= 1'b1;
                bit_cnt <= '0;
            end else if (stop_p) begin
                armed <= 1'b0;
            end else if (armed && clk_rise) begin
                if (bit_cnt == CW'(BYTE_W)) begin
                    // ninth clock: acknowledge slot, byte complete
                    byte_vld <= 1'b1;
                    armed    <= 1'b0;
                end else begin
                    byte_q  <= {byte_q[BYTE_W-2:0], dat_q};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mbb_hang_timer.sv
module mbb_hang_timer #(
    parameter int LIMIT = 125000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_q,
    output logic hang
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || scl_q)            cnt <= '0;
        else if (cnt != CW'(LIMIT))  cnt <= cnt + 1'b1;
    end

    assign hang = (cnt == CW'(LIMIT));
endmodule

// File: rtl/mbb_bridge_ctrl.sv
module mbb_bridge_ctrl
    import mbb_pkg::*;
#(
    parameter int HANG_CYCLES = 125000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sdah_i,
    input  logic       sclh_i,
    input  logic       sda_i,
    input  logic       scl_i,
    output logic       data_join_o,
    output logic       clk_join_o,
    output logic       sda_pull_o,
    output logic [1:0] state_o
);
    bus_lines_t raw_lines, lines_q;
    logic       sdah_q, sclh_q, sda_q, scl_q;

    assign raw_lines = '{sdah: sdah_i, sclh: sclh_i, sda: sda_i, scl: scl_i};

    mbb_line_sync #(.WIDTH(LINE_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_lines), .q(lines_q)
    );

    assign sdah_q = lines_q.sdah;
    assign sclh_q = lines_q.sclh;
    assign sda_q  = lines_q.sda;
    assign scl_q  = lines_q.scl;

    logic start_p, stop_p, clk_rise;

    mbb_cond_det u_cond (
        .clk(clk), .rst(rst), .dat_q(sdah_q), .clk_q(sclh_q),
        .start_p(start_p), .stop_p(stop_p), .clk_rise(clk_rise)
    );

    logic              byte_vld;
    logic [BYTE_W-1:0] byte_q;

    mbb_byte_rx u_rx (
        .clk(clk), .rst(rst), .start_p(start_p), .stop_p(stop_p),
        .clk_rise(clk_rise), .dat_q(sdah_q), .byte_vld(byte_vld), .byte_q(byte_q)
    );

    logic hang;

    mbb_hang_timer #(.LIMIT(HANG_CYCLES)) u_hang (
        .clk(clk), .rst(rst), .scl_q(scl_q), .hang(hang)
    );

    br_state_e  state;
    logic [1:0] step;
    sw_ctl_t    sw;

    always_ff @(posedge clk) begin
        if (rst || hang) begin
            state <= BR_CLOSED;
            step  <= '0;
            sw    <= SW_CLOSED;
        end else begin
            case (state)
                BR_CLOSED: begin
                    if (byte_vld && is_master_code(byte_q)) begin
                        sw.data_join <= 1'b0;
                        step         <= 2'd0;
                        state        <= BR_SPLITTING;
                    end
                end
                BR_SPLITTING: begin
                    case (step)
                        2'd0: begin
                            sw.sda_pull <= 1'b1;
                            step        <= 2'd1;
                        end
                        2'd1: if (!sclh_q) step <= 2'd2;
                        default: begin
                            if (sclh_q && scl_q) begin
                                sw.clk_join <= 1'b0;
                                state       <= BR_SPLIT;
                            end
                        end
                    endcase
                end
                BR_SPLIT: begin
                    if (stop_p) begin
                        sw.clk_join <= 1'b1;
                        step        <= 2'd0;
                        state       <= BR_REJOIN;
                    end
                end
                default: begin
                    if (step == 2'd0) begin
                        sw.sda_pull <= 1'b0;
                        step        <= 2'd1;
                    end else if (sda_q) begin
                        sw.data_join <= 1'b1;
                        state        <= BR_CLOSED;
                    end
                end
            endcase
        end
    end

    assign data_join_o = sw.data_join;
    assign clk_join_o  = sw.clk_join;
    assign sda_pull_o  = sw.sda_pull;
    assign state_o     = state;
endmodule

// File: rtl/mbb_bridge_chk.sv
module mbb_bridge_chk (
    input logic       clk,
    input logic       rst,
    input logic       sclh_q,
    input logic       scl_q,
    input logic       sda_q,
    input logic       stop_p,
    input logic       hang,
    input logic       data_join,
    input logic       clk_join,
    input logic       sda_pull,
    input logic [1:0] state
);
    a_r1_reset_closed: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (data_join && clk_join && !sda_pull && state == 2'd0));

    a_r4_pull_after_open: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> $past(!data_join));

    a_r4_no_pull_joined: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> !data_join);

    a_r5_clk_open_high: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_join) |-> $past(sclh_q && scl_q));

    a_r6_split_outputs: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd2) |-> (!data_join && !clk_join && sda_pull));

    a_r7_clk_close_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_join) |-> $past(stop_p || hang));

    a_r8_data_close_sda_high: assert property (@(posedge clk) disable iff (rst)
        $rose(data_join) |-> $past(sda_q || hang));

    a_r9_hang_closes: assert property (@(posedge clk) disable iff (rst)
        hang |=> (data_join && clk_join && !sda_pull && state == 2'd0));

    a_r10_closed_outputs: assert property (@(posedge clk) disable iff (rst)
        (state == 2'd0) |-> (data_join && clk_join && !sda_pull));
endmodule

bind mbb_bridge_ctrl mbb_bridge_chk u_chk (
    .clk(clk), .rst(rst), .sclh_q(sclh_q), .scl_q(scl_q), .sda_q(sda_q),
    .stop_p(stop_p), .hang(hang), .data_join(data_join_o), .clk_join(clk_join_o),
    .sda_pull(sda_pull_o), .state(state_o)
);

// File: tb/tb_mbb_bridge_ctrl.sv
module tb_mbb_bridge_ctrl;
    localparam int HANG = 300;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sdah = 1'b1, sclh = 1'b1, sda = 1'b1, scl = 1'b1;
    logic       dj, cj, pl;
    logic [1:0] st;

    always #4 clk = ~clk;

    mbb_bridge_ctrl #(.HANG_CYCLES(HANG)) dut (
        .clk(clk), .rst(rst), .sdah_i(sdah), .sclh_i(sclh), .sda_i(sda), .scl_i(scl),
        .data_join_o(dj), .clk_join_o(cj), .sda_pull_o(pl), .state_o(st)
    );

    int tests = 0, fails = 0;
    bit done = 0;

    // edge-time monitor for the R4 ordering
    int cyc = 0, t_open = -1, t_pull = -1;
    logic prev_dj = 1'b1, prev_pl = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_dj && !dj) t_open = cyc;
        if (!prev_pl && pl) t_pull = cyc;
        prev_dj = dj;
        prev_pl = pl;
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lines(input logic a, input logic b, input logic c, input logic d, input int n);
        sdah = a; sclh = b; sda = c; scl = d;
        hold(n);
    endtask

    task automatic joint(input logic d, input logic c, input int n);
        lines(d, c, d, c, n);
    endtask

    task automatic chk_closed(input string req);
        chk({req, " data_join"}, dj, 1);
        chk({req, " clk_join"},  cj, 1);
        chk({req, " sda_pull"},  pl, 0);
        chk({req, " state"},     st, 0);
    endtask

    task automatic send_first_byte(input logic [7:0] code);
        joint(1, 1, 6);
        joint(0, 1, 6);
        joint(0, 0, 6);
        for (int i = 7; i >= 0; i--) begin
            joint(code[i], 0, 6);
            joint(code[i], 1, 6);
            joint(code[i], 0, 6);
        end
        joint(1, 0, 6);
        joint(1, 1, 6);
        joint(1, 0, 6);
    endtask

    task automatic go_split(input logic [7:0] code);
        t_open = -1; t_pull = -1;
        send_first_byte(code);
        chk("R2 splitting state", st, 1);
        chk("R2 data switch open", dj, 0);
        chk("R4 pull one cycle after open", t_pull - t_open, 1);
        chk("R5 clk joined while clocks low", cj, 1);
        lines(1, 1, 0, 0, 10);
        chk("R5 clk joined with slow clock low", cj, 1);
        lines(1, 1, 0, 1, 6);
        chk("R5 clk open when both high", cj, 0);
        chk("R10 split code", st, 2);
    endtask

    task automatic rejoin();
        lines(0, 1, 0, 1, 6);
        lines(1, 1, 0, 1, 6);
        chk("R7 rejoin state", st, 3);
        chk("R7 clk rejoined", cj, 1);
        chk("R7 pull released", pl, 0);
        chk("R8 data held open while sda low", dj, 0);
        lines(1, 1, 1, 1, 6);
        chk("R8 data rejoined", dj, 1);
        chk("R8 back to closed", st, 0);
    endtask

    // {first byte, 1 = master code expected}
    localparam logic [8:0] VEC [8] = '{
        {8'h08, 1'b1}, {8'h0F, 1'b1}, {8'h0B, 1'b1},
        {8'h00, 1'b0}, {8'h07, 1'b0}, {8'h10, 1'b0},
        {8'hA0, 1'b0}, {8'h88, 1'b0}
    };

    initial begin
        hold(4);
        rst = 1'b0;
        hold(2);
        chk_closed("R1 after reset");

        foreach (VEC[k]) begin
            if (VEC[k][0]) begin
                go_split(VEC[k][8:1]);
                // high-speed activity: repeated START and a few bits
                lines(0, 1, 0, 1, 6);
                lines(0, 0, 0, 1, 4);
                lines(1, 0, 0, 1, 4);
                lines(1, 1, 0, 1, 4);
                lines(0, 0, 0, 1, 4);
                lines(0, 1, 0, 1, 4);
                chk("R6 split held", st, 2);
                chk("R6 pull held", pl, 1);
                rejoin();
            end else begin
                send_first_byte(VEC[k][8:1]);
                chk_closed("R3 non-master byte");
                joint(0, 0, 6);
                joint(0, 1, 6);
                joint(1, 1, 6);
                chk_closed("R3 after stop");
            end
        end

        // R11: one-sample data pulse while high-speed clock is high
        go_split(8'h08);
        lines(0, 1, 0, 1, 6);
        lines(1, 1, 0, 1, 1);
        lines(0, 1, 0, 1, 10);
        chk("R11 glitch ignored state", st, 2);
        chk("R11 glitch clk still open", cj, 0);
        rejoin();

        // R9: slow clock stuck low
        go_split(8'h09);
        lines(1, 1, 0, 0, 250);
        chk("R9 not yet timed out", st, 2);
        lines(1, 1, 0, 1, 5);
        lines(1, 1, 0, 0, 250);
        chk("R9 count restarted by high", st, 2);
        lines(1, 1, 0, 0, 60);
        chk_closed("R9 forced closed");
        joint(1, 1, 10);
        chk_closed("R9 stays closed after release");

        // R1: reset in the middle of a split
        go_split(8'h0A);
        rst = 1'b1;
        hold(2);
        rst = 1'b0;
        hold(1);
        chk_closed("R1 reset mid-split");
        joint(1, 1, 10);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule